// File: doc/BRIEF.md
# Serial Three-Wire Memory Command Engine

This block is the slave side of a three-wire serial memory. A host selects it, shifts a command in on the data input and receives read data or a ready/busy indication on a data output that can be tri-stated. Every command opens with a start bit and a two-bit opcode. An address field follows. Under one shared opcode the top two address bits select one of four housekeeping commands. A compile-time parameter sets the storage shape: 512 bytes, or 256 sixteen-bit words.

All three serial inputs pass through synchronizers into the system clock domain, and the engine acts on the detected rising edges of the serial clock. Write data is collected in a page buffer. When the select line is released, the engine issues a one-cycle commit request to an external program-cycle controller. That controller reports busy while it works, and the host can poll this status by selecting the block again. The storage array is modelled as registers, and it takes the committed update on the cycle after the request.

A single finite state machine runs each transaction. Its states are ST_IDLE (waiting for a start bit, or reporting status), ST_OPC (collecting the opcode), ST_ADDR (collecting the address), ST_READ (streaming data), ST_WDATA (collecting write units) and ST_HOLD (discarding clocks until the block is deselected). The transitions are: idle to opcode on a 1 sampled as the start bit; opcode to address after two bits; address to read, write-data or hold after the last address bit, depending on the decode; and any state back to idle whenever select is low.

Top module: `mw_cmd_engine`

## Requirements
- R1: The engine ignores 0 bits clocked in while it waits. The first 1 is the start bit. It is followed by a 2-bit opcode and then the address, both MSB first. The address is 9 bits in byte mode and 8 bits in word mode. Opcode 10 is read, 01 is write, 11 is erase single and 00 is housekeeping.
- R2: For opcode 00, the top two address bits select the command: 11 enables writing, 00 disables writing, 10 erases everything, and 01 writes every location with one data unit that follows the address.
- R3: A read drives a single 0 on the data output from the rising serial clock edge that samples the last address bit. The addressed unit follows, MSB first, one bit per further rising edge. After reset, every location reads as all ones.
- R4: While select stays high, a read continues into the next address, and the address wraps from the top location to 0.
- R5: A write accepts one or more data units. Each complete unit goes to the next address, and the address wraps inside its page: 16 bytes (low 4 bits) or 8 words (low 3 bits). A partial unit is dropped. The array does not change until select falls.
- R6: A single erase sets the addressed location to all ones. Erase-everything sets every location to all ones. Write-everything copies its data unit into every location.
- R7: Writing is disabled after reset. A write, erase, erase-everything or write-everything issued while writing is disabled produces no commit request and leaves every location unchanged. The enable persists until the disable command.
- R8: Reads return stored data whether writing is enabled or disabled.
- R9: When select is low, the output enable is 0 and any partial command is abandoned, so a new read needs a full command.
- R10: After a commit, raising select before any start bit drives the data output with the inverse of the busy input. The next start bit stops this drive.
- R11: A commit is a one-cycle pulse on commit request, after select falls. It carries the kind (0 write, 1 erase single, 2 erase everything, 3 write everything) and the address: the first address of a write, the erased address, or 0 for the whole-array kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| prog_busy_i | input | 1 | Busy flag from the program-cycle controller |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for the data out pin |
| commit_req_o | output | 1 | One-cycle commit request |
| commit_op_o | output | 2 | Commit kind |
| commit_addr_o | output | AW (9 or 8) | Commit address |

## Verification
Some properties are checked on every cycle. The output enable drops once select is low, and a commit request appears only while writing is enabled and just after select falls. Each read begins with a driven 0, and the page bits of the write pointer never change inside one write. Only the bench scenarios can show the data itself: units read back from the right addresses, page wrap and full-array wrap, commands dropped while writing is disabled, erase values, the status polarity, and recovery after an abandoned read.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_READ,
        ST_WDATA,
        ST_HOLD
    } mw_state_e;

    typedef enum logic [1:0] {
        CM_WRITE = 2'd0,
        CM_ERASE = 2'd1,
        CM_ERAL  = 2'd2,
        CM_WRAL  = 2'd3
    } mw_commit_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_DIS  = 2'b00;
    localparam logic [1:0] SUB_WRAL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_EN   = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl_o  = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
    assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 9,
    parameter int PB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          buf_we_i,
    input  logic [PB-1:0] buf_idx_i,
    input  logic [DW-1:0] buf_data_i,
    input  logic          commit_i,
    input  mw_commit_e    commit_op_i,
    input  logic [AW-1:0] commit_addr_i
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PB;

    logic [DW-1:0]   mem  [DEPTH];
    logic [DW-1:0]   pbuf [PAGE];
    logic [PAGE-1:0] pmask;

    assign rd_data_o = mem[rd_addr_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem[j] <= '1;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
            pmask <= '0;
        end else begin
            if (buf_we_i) begin
                pbuf[buf_idx_i]  <= buf_data_i;
                pmask[buf_idx_i] <= 1'b1;
            end
            if (commit_i) begin
                unique case (commit_op_i)
                    CM_WRITE: begin
                        for (int i = 0; i < PAGE; i++) begin
                            if (pmask[i])
                                mem[{commit_addr_i[AW-1:PB], PB'(i)}] <= pbuf[i];
                        end
                    end
                    CM_ERASE: mem[commit_addr_i] <= '1;
                    CM_ERAL: for (int j = 0; j < DEPTH; j++) mem[j] <= '1;
                    CM_WRAL: for (int j = 0; j < DEPTH; j++) mem[j] <= pbuf[0];
                endcase
                pmask <= '0;
            end
        end
    end
endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
    import mw_pkg::*;
#(
    parameter bit WORD_MODE   = 1'b0,
    parameter int SYNC_STAGES = 2,
    localparam int DW = WORD_MODE ? 16 : 8,
    localparam int AW = WORD_MODE ? 8 : 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          sk_i,
    input  logic          di_i,
    input  logic          prog_busy_i,
    output logic          do_o,
    output logic          do_oe_o,
    output logic          commit_req_o,
    output logic [1:0]    commit_op_o,
    output logic [AW-1:0] commit_addr_o
);
    localparam int PB = WORD_MODE ? 3 : 4;
    localparam int MW = (DW > AW) ? DW : AW;
    localparam int CW = $clog2(MW) + 1;

    logic cs_lvl, cs_rise_unused, cs_fall;
    logic sk_lvl_unused, sk_rise, sk_fall_unused;
    logic di_lvl, di_rise_unused, di_fall_unused;

    mw_sync #(.STAGES(SYNC_STAGES)) u_cs (
        .clk(clk), .rst_n(rst_n), .d_i(cs_i),
        .lvl_o(cs_lvl), .rise_o(cs_rise_unused), .fall_o(cs_fall));
    mw_sync #(.STAGES(SYNC_STAGES)) u_sk (
        .clk(clk), .rst_n(rst_n), .d_i(sk_i),
        .lvl_o(sk_lvl_unused), .rise_o(sk_rise), .fall_o(sk_fall_unused));
    mw_sync #(.STAGES(SYNC_STAGES)) u_di (
        .clk(clk), .rst_n(rst_n), .d_i(di_i),
        .lvl_o(di_lvl), .rise_o(di_rise_unused), .fall_o(di_fall_unused));

    mw_state_e     state, state_n, addr_target;
    logic [CW-1:0] cnt;
    logic [1:0]    op_q;
    logic [AW-1:0] addr_q, rd_ptr, wptr, base_q;
    logic [DW-1:0] dsh, rsh, rd_data;
    logic          wen_q, pend_q, stat_q, do_q, oe_q;
    mw_commit_e    pend_op, cm_op;
    logic          cm_req;
    logic [AW-1:0] cm_addr;
    logic          bwe_q;
    logic [PB-1:0] bidx_q;
    logic [DW-1:0] bdat_q;

    logic [AW-1:0] full_addr;
    logic [1:0]    sub;
    logic          last_addr_bit, last_data_bit;

    assign full_addr     = {addr_q[AW-2:0], di_lvl};
    assign sub           = full_addr[AW-1:AW-2];
    assign last_addr_bit = (cnt == CW'(AW-1));
    assign last_data_bit = (cnt == CW'(DW-1));

    // Decode target of the address phase
    always_comb begin
        addr_target = ST_HOLD;
        unique case (op_q)
            OPC_READ:  addr_target = ST_READ;
            OPC_WRITE: addr_target = wen_q ? ST_WDATA : ST_HOLD;
            OPC_ERASE: addr_target = ST_HOLD;
            OPC_EXT:   addr_target = (sub == SUB_WRAL && wen_q) ? ST_WDATA : ST_HOLD;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (!cs_lvl) begin
            state_n = ST_IDLE;
        end else if (sk_rise) begin
            unique case (state)
                ST_IDLE:  if (di_lvl) state_n = ST_OPC;
                ST_OPC:   if (cnt == CW'(1)) state_n = ST_ADDR;
                ST_ADDR:  if (last_addr_bit) state_n = addr_target;
                ST_READ, ST_WDATA, ST_HOLD: state_n = state;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            rd_ptr  <= '0;
            wptr    <= '0;
            base_q  <= '0;
            dsh     <= '0;
            rsh     <= '0;
            wen_q   <= 1'b0;
            pend_q  <= 1'b0;
            pend_op <= CM_WRITE;
            stat_q  <= 1'b0;
            do_q    <= 1'b0;
            oe_q    <= 1'b0;
            cm_req  <= 1'b0;
            cm_op   <= CM_WRITE;
            cm_addr <= '0;
            bwe_q   <= 1'b0;
            bidx_q  <= '0;
            bdat_q  <= '0;
        end else begin
            cm_req <= 1'b0;
            bwe_q  <= 1'b0;
            if (cs_fall && pend_q) begin
                cm_req  <= 1'b1;
                cm_op   <= pend_op;
                cm_addr <= base_q;
                stat_q  <= 1'b1;
                pend_q  <= 1'b0;
            end
            if (!cs_lvl) begin
                oe_q <= 1'b0;
                cnt  <= '0;
            end else begin
                if (state == ST_IDLE && stat_q) begin
                    oe_q <= 1'b1;
                    do_q <= ~prog_busy_i;
                end
                if (sk_rise) begin
                    unique case (state)
                        ST_IDLE: begin
                            if (di_lvl) begin
                                cnt    <= '0;
                                stat_q <= 1'b0;
                                oe_q   <= 1'b0;
                            end
                        end
                        ST_OPC: begin
                            op_q <= {op_q[0], di_lvl};
                            cnt  <= (cnt == CW'(1)) ? '0 : cnt + 1'b1;
                        end
                        ST_ADDR: begin
                            addr_q <= full_addr;
                            cnt    <= last_addr_bit ? '0 : cnt + 1'b1;
                            if (last_addr_bit) begin
                                unique case (op_q)
                                    OPC_READ: begin
                                        oe_q   <= 1'b1;
                                        do_q   <= 1'b0;
                                        rd_ptr <= full_addr;
                                    end
                                    OPC_WRITE: begin
                                        base_q  <= full_addr;
                                        wptr    <= full_addr;
                                        pend_op <= CM_WRITE;
                                    end
                                    OPC_ERASE: begin
                                        if (wen_q) begin
                                            pend_q  <= 1'b1;
                                            pend_op <= CM_ERASE;
                                            base_q  <= full_addr;
                                        end
                                    end
                                    OPC_EXT: begin
                                        unique case (sub)
                                            SUB_EN:  wen_q <= 1'b1;
                                            SUB_DIS: wen_q <= 1'b0;
                                            SUB_ERAL: begin
                                                if (wen_q) begin
                                                    pend_q  <= 1'b1;
                                                    pend_op <= CM_ERAL;
                                                    base_q  <= '0;
                                                end
                                            end
                                            SUB_WRAL: begin
                                                pend_op <= CM_WRAL;
                                                base_q  <= '0;
                                                wptr    <= '0;
                                            end
                                        endcase
                                    end
                                endcase
                            end
                        end
                        ST_READ: begin
                            if (cnt == '0) begin
                                do_q <= rd_data[DW-1];
                                rsh  <= {rd_data[DW-2:0], 1'b0};
                            end else begin
                                do_q <= rsh[DW-1];
                                rsh  <= {rsh[DW-2:0], 1'b0};
                            end
                            if (last_data_bit) begin
                                cnt    <= '0;
                                rd_ptr <= rd_ptr + 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            dsh <= {dsh[DW-2:0], di_lvl};
                            if (last_data_bit) begin
                                cnt    <= '0;
                                bwe_q  <= 1'b1;
                                bidx_q <= wptr[PB-1:0];
                                bdat_q <= {dsh[DW-2:0], di_lvl};
                                wptr   <= {wptr[AW-1:PB], wptr[PB-1:0] + 1'b1};
                                pend_q <= 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_HOLD: cnt <= cnt;
                    endcase
                end
            end
        end
    end

    mw_array #(.DW(DW), .AW(AW), .PB(PB)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_i(rd_ptr), .rd_data_o(rd_data),
        .buf_we_i(bwe_q), .buf_idx_i(bidx_q), .buf_data_i(bdat_q),
        .commit_i(cm_req), .commit_op_i(cm_op), .commit_addr_i(cm_addr));

    assign do_o          = do_q;
    assign do_oe_o       = oe_q;
    assign commit_req_o  = cm_req;
    assign commit_op_o   = cm_op;
    assign commit_addr_o = cm_addr;

    a_r9_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |=> !do_oe_o);

    a_r7_commit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req_o |-> wen_q);

    a_r11_commit_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req_o |-> ($past(cs_fall) && !$past(commit_req_o)));

    a_r3_dummy_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_READ) |-> (do_oe_o && !do_o));

    a_r5_page_bits_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && $past(state) == ST_WDATA)
            |-> wptr[AW-1:PB] == $past(wptr[AW-1:PB]));
endmodule

// File: tb/mw_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module mw_cmd_engine_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, busy = 1'b0;
    logic do_o, do_oe;
    logic commit_req;
    logic [1:0] commit_op;
    logic [8:0] commit_addr;

    always #2.5 clk = ~clk;

    mw_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .prog_busy_i(busy), .do_o(do_o), .do_oe_o(do_oe),
        .commit_req_o(commit_req), .commit_op_o(commit_op),
        .commit_addr_o(commit_addr));

    typedef struct { logic dv; string tag; } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0;
    int ncommit = 0, exp_ncommit = 0;
    logic [1:0] last_op;
    logic [8:0] last_addr;
    logic [7:0] model [512];
    bit m_wen = 1'b0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare serial output at each falling serial clock
    always @(negedge sk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            chk(it.tag, {30'd0, do_oe, do_o}, {30'd0, 1'b1, it.dv});
        end
    end

    always @(posedge clk) begin
        if (commit_req) begin
            ncommit   <= ncommit + 1;
            last_op   <= commit_op;
            last_addr <= commit_addr;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sk_cycle(input logic d, input bit c, input logic e, input string tag);
        di = d;
        wclk(4);
        if (c) exp_q.push_back('{dv: e, tag: tag});
        sk = 1'b1;
        wclk(8);
        sk = 1'b0;
        wclk(4);
    endtask

    task automatic cs_high();
        cs = 1'b1;
        wclk(4);
    endtask

    task automatic cs_low();
        cs = 1'b0;
        wclk(10);
    endtask

    task automatic header(input logic [1:0] op, input logic [8:0] a, input bit rd);
        sk_cycle(1'b1, 0, 0, "");
        sk_cycle(op[1], 0, 0, "");
        sk_cycle(op[0], 0, 0, "");
        for (int i = 8; i >= 0; i--)
            sk_cycle(a[i], rd && i == 0, 1'b0, "R3 dummy zero");
    endtask

    task automatic expect_commit(input string tag, input bit yes,
                                 input logic [1:0] op, input logic [8:0] a);
        if (yes) exp_ncommit++;
        chk({tag, " count"}, ncommit, exp_ncommit);
        if (yes) begin
            chk({tag, " kind"}, {30'd0, last_op}, {30'd0, op});
            chk({tag, " addr"}, {23'd0, last_addr}, {23'd0, a});
        end
    endtask

    task automatic do_read(input int a, input int n, input int pre);
        cs_high();
        for (int p = 0; p < pre; p++) sk_cycle(1'b0, 0, 0, "");
        header(2'b10, 9'(a), 1'b1);
        for (int u = 0; u < n; u++)
            for (int b = 7; b >= 0; b--)
                sk_cycle(1'b0, 1, model[(a + u) % 512][b], u > 0 ? "R4 next unit" : "R3 read data");
        cs_low();
        chk("R9 oe off after deselect", {31'd0, do_oe}, 32'd0);
    endtask

    task automatic do_write(input int a, input int n, input logic [23:0] dd);
        cs_high();
        header(2'b01, 9'(a), 1'b0);
        for (int u = 0; u < n; u++)
            for (int b = 7; b >= 0; b--)
                sk_cycle(dd[23 - 8*u - (7 - b)], 0, 0, "");
        cs_low();
        if (m_wen)
            for (int u = 0; u < n; u++)
                model[{a[8:4], 4'(a[3:0] + u)}] = dd[23 - 8*u -: 8];
        expect_commit("R11 R5 write commit", m_wen, 2'd0, 9'(a));
    endtask

    task automatic do_erase(input int a);
        cs_high();
        header(2'b11, 9'(a), 1'b0);
        cs_low();
        if (m_wen) model[a] = 8'hFF;
        expect_commit("R6 R7 erase commit", m_wen, 2'd1, 9'(a));
    endtask

    task automatic do_ext(input logic [1:0] sub, input logic [7:0] d);
        cs_high();
        header(2'b00, {sub, 7'd0}, 1'b0);
        if (sub == 2'b01)
            for (int b = 7; b >= 0; b--) sk_cycle(d[b], 0, 0, "");
        cs_low();
        case (sub)
            2'b11: m_wen = 1'b1;
            2'b00: m_wen = 1'b0;
            2'b10: begin
                if (m_wen) for (int j = 0; j < 512; j++) model[j] = 8'hFF;
                expect_commit("R2 R6 erase-all commit", m_wen, 2'd2, 9'd0);
            end
            default: begin
                if (m_wen) for (int j = 0; j < 512; j++) model[j] = d;
                expect_commit("R2 R6 write-all commit", m_wen, 2'd3, 9'd0);
            end
        endcase
    endtask

    task automatic finish_run();
        wclk(20);
        chk("queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 512; j++) model[j] = 8'hFF;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        chk("R9 reset oe", {31'd0, do_oe}, 32'd0);
        chk("R11 reset commit", {31'd0, commit_req}, 32'd0);

        // R1 leading zeros ignored; R3 erased reset content
        do_read(5, 1, 2);

        // R7 write while disabled: no commit; R8 read still works
        do_write(5, 1, 24'hA50000);
        do_read(5, 1, 0);

        // R2 enable, then a real write
        do_ext(2'b11, 8'h00);
        do_write(5, 1, 24'hA50000);

        // R10 status polling
        busy = 1'b1;
        cs_high();
        wclk(4);
        chk("R10 busy drives 0", {30'd0, do_oe, do_o}, {30'd0, 2'b10});
        busy = 1'b0;
        wclk(6);
        chk("R10 ready drives 1", {30'd0, do_oe, do_o}, {30'd0, 2'b11});
        sk_cycle(1'b1, 0, 0, "");
        chk("R10 start bit stops status", {31'd0, do_oe}, 32'd0);
        cs_low();

        // R4 continuous read into next address
        do_read(5, 2, 0);

        // R5 page write wrapping inside the 16-byte page
        do_write(9'h01E, 3, 24'h112233);
        do_read(9'h01E, 3, 0);
        do_read(9'h010, 1, 0);

        // R6 single erase
        do_erase(5);
        do_read(5, 1, 0);

        // R2 R6 write-all then erase-all
        do_ext(2'b01, 8'h96);
        do_read(9'h1FF, 2, 0);
        do_ext(2'b10, 8'h00);
        do_write(0, 1, 24'h3C0000);
        // R4 wrap from top address to 0
        do_read(9'h1FF, 2, 0);

        // R7 disable: erase and write dropped; R8 reads unaffected
        do_ext(2'b00, 8'h00);
        do_erase(0);
        do_write(1, 1, 24'h770000);
        do_ext(2'b10, 8'h00);
        do_read(0, 2, 0);

        // R9 abandoned read then a full new command
        cs_high();
        header(2'b10, 9'd0, 1'b1);
        sk_cycle(1'b0, 1, model[0][7], "R9 partial read");
        sk_cycle(1'b0, 1, model[0][6], "R9 partial read");
        cs_low();
        chk("R9 oe off mid-read", {31'd0, do_oe}, 32'd0);
        do_read(0, 1, 0);

        done = 1'b1;
        finish_run();
    end
endmodule